// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block sits in front of a synchronous burst SRAM array and supplies the word address that the array uses in each cycle. On every rising clock edge it samples an external address, two burst-start strobes (a processor-side strobe and a controller-side strobe), an advance input, a chip enable and an order-select input. A qualified start strobe loads the external address and clears a small burst counter. Later advance cycles step the low address bits through a four-word burst, in either linear or interleaved order.

The processor-side strobe counts only while the chip enable is active. The controller-side strobe loads when the chip enable is active and deselects the block when it is not. With advance low the current address is held, which suspends the burst. A new external address may be loaded on any cycle, so bursting is optional. Alongside the address, the block gives a valid flag and a two-bit cycle-type code for the downstream array.

Top module: `burstAddrGen`

## Requirements
- R1: While reset is low and after its release, curAddr is 0, addrValid is 0 and cycType is 0 (idle).
- R2: When procStart and chipEn are both high at a rising edge, then after that edge curAddr equals the sampled extAddr, addrValid is 1 and cycType is 1 (load).
- R3: When ctrlStart and chipEn are high and procStart is low at a rising edge, the block loads extAddr in the same way as in R2 (cycType 1, addrValid 1).
- R4: procStart is ignored when chipEn is low. The edge then behaves as if procStart were low: with no other strobe and advance low, curAddr and addrValid keep their values; with advance high during a valid burst, the address steps.
- R5: ctrlStart with chipEn low deselects the block. After that edge addrValid is 0 and cycType is 0, and curAddr holds its value.
- R6: With linearOrder low at the load edge (interleaved order, which is also the default), after n advances the low two address bits equal the starting low bits XOR (n mod 4). Each stepping edge gives cycType 2 (step).
- R7: With linearOrder high at the load edge (linear order), after n advances the low two bits equal (starting low bits + n) mod 4.
- R8: With addrValid high, no qualified strobe and advance low, curAddr holds, addrValid stays 1 and cycType is 3 (hold).
- R9: During a burst the address bits above the low two never change. After four advances the address wraps back to the loaded address.
- R10: The order is captured at the load edge. A change of linearOrder during a burst has no effect on the stepping sequence.
- R11: Advance while addrValid is 0 has no effect: curAddr stays unchanged, addrValid stays 0 and cycType stays 0.
- R12: Loads on consecutive cycles each take the newly sampled address, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extAddr | input | AW | External word address |
| procStart | input | 1 | Processor-side burst start, qualified by chipEn |
| ctrlStart | input | 1 | Controller-side burst start; deselects when chipEn is low |
| advance | input | 1 | Step the burst counter |
| chipEn | input | 1 | Primary chip enable |
| linearOrder | input | 1 | 1 selects linear order, 0 selects interleaved order |
| curAddr | output | AW | Current internal word address |
| addrValid | output | 1 | The address addresses an active cycle |
| cycType | output | 2 | 0 idle, 1 load, 2 step, 3 hold |

## Verification
The properties assume that every input is a clean 0 or 1 at each rising edge and that the address width exceeds the burst counter width. Under that assumption the next state is fully set by the sampled strobes. The stimulus changes inputs only a short time after each rising edge and holds them for the rest of the cycle, so each edge sees one settled combination. The strobe mixes are chosen so that every priority branch is reached: both strobes together, each strobe alone with chipEn high and low, and advance with and without a valid burst.

// File: rtl/burstAddrPkg.sv
package burstAddrPkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_LOAD  = 2'd1,
    CYC_STEP  = 2'd2,
    CYC_HOLD  = 2'd3
  } cyc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } strobes_t;
endpackage

// File: rtl/burstAddrCtrl.sv
module burstAddrCtrl
  import burstAddrPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     procStart,
  input  logic     ctrlStart,
  input  logic     advance,
  input  logic     chipEn,
  output strobes_t stb,
  output logic     validQ,
  output cyc_t     cycQ
);
  logic procHit;
  logic ctrlHit;
  logic dropHit;
  logic validD;
  cyc_t cycD;

  // processor strobe wins; it only counts with chip enable active
  always_comb begin
    procHit = procStart && chipEn;
    ctrlHit = !procHit && ctrlStart && chipEn;
    dropHit = !procHit && ctrlStart && !chipEn;
    stb.load = procHit || ctrlHit;
    stb.step = !stb.load && !dropHit && validQ && advance;
  end

  always_comb begin
    if (stb.load) begin
      validD = 1'b1;
      cycD   = CYC_LOAD;
    end else if (dropHit) begin
      validD = 1'b0;
      cycD   = CYC_IDLE;
    end else if (stb.step) begin
      validD = 1'b1;
      cycD   = CYC_STEP;
    end else begin
      validD = validQ;
      cycD   = validQ ? CYC_HOLD : CYC_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      cycQ   <= CYC_IDLE;
    end else begin
      validQ <= validD;
      cycQ   <= cycD;
    end
  end
endmodule

// File: rtl/burstAddrPath.sv
module burstAddrPath
  import burstAddrPkg::*;
#(
  parameter int AW = 20,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      stb,
  input  logic [AW-1:0] extAddr,
  input  logic          linearOrder,
  output logic [AW-1:0] curAddr
);
  logic [AW-1:0] baseQ;
  logic [BB-1:0] cntQ;
  logic          linQ;
  logic [BB-1:0] lowLin;
  logic [BB-1:0] lowIlv;
  logic [BB-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
      linQ  <= 1'b0;
    end else if (stb.load) begin
      baseQ <= extAddr;
      cntQ  <= '0;
      linQ  <= linearOrder;
    end else if (stb.step) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  assign lowLin = baseQ[BB-1:0] + cntQ;

  // interleaved order: each low bit toggles with its count bit
  for (genvar i = 0; i < BB; i++) begin : g_ilv
    assign lowIlv[i] = baseQ[i] ^ cntQ[i];
  end

  assign lowBits = linQ ? lowLin : lowIlv;
  assign curAddr = {baseQ[AW-1:BB], lowBits};
endmodule

// File: rtl/burstAddrGen.sv
module burstAddrGen
  import burstAddrPkg::*;
#(
  parameter int AW = 20,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] extAddr,
  input  logic          procStart,
  input  logic          ctrlStart,
  input  logic          advance,
  input  logic          chipEn,
  input  logic          linearOrder,
  output logic [AW-1:0] curAddr,
  output logic          addrValid,
  output logic [1:0]    cycType
);
  strobes_t stb;
  cyc_t     cycQ;

  burstAddrCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .procStart(procStart), .ctrlStart(ctrlStart),
    .advance(advance), .chipEn(chipEn), .stb(stb), .validQ(addrValid), .cycQ(cycQ)
  );

  burstAddrPath #(.AW(AW), .BB(BB)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .extAddr(extAddr),
    .linearOrder(linearOrder), .curAddr(curAddr)
  );

  assign cycType = cycQ;
endmodule

// File: rtl/burstAddrGenChk.sv
module burstAddrGenChk #(
  parameter int AW = 20,
  parameter int BB = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] extAddr,
  input logic          procStart,
  input logic          ctrlStart,
  input logic          advance,
  input logic          chipEn,
  input logic          linearOrder,
  input logic [AW-1:0] curAddr,
  input logic          addrValid,
  input logic [1:0]    cycType
);
  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    chipEn && (procStart || ctrlStart) |=> curAddr == $past(extAddr) && addrValid && cycType == 2'd1); // R2

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn && ctrlStart |=> !addrValid && cycType == 2'd0 && $stable(curAddr)); // R5

  AST_PROC_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn && procStart && !ctrlStart && !advance |=> $stable(curAddr) && $stable(addrValid)); // R4

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !advance && !ctrlStart && !(procStart && chipEn) |=> $stable(curAddr) && addrValid && cycType == 2'd3); // R8

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && advance && !ctrlStart && !(procStart && chipEn) |=> curAddr[AW-1:BB] == $past(curAddr[AW-1:BB]) && cycType == 2'd2); // R9

  AST_IDLE_ADV_NOEFFECT: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid && !ctrlStart && !(procStart && chipEn) |=> !addrValid && $stable(curAddr)); // R11

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |-> curAddr == '0 && !addrValid && cycType == 2'd0); // R1
endmodule

bind burstAddrGen burstAddrGenChk #(.AW(AW), .BB(BB)) u_chk (
  .clk(clk), .rstN(rstN), .extAddr(extAddr), .procStart(procStart),
  .ctrlStart(ctrlStart), .advance(advance), .chipEn(chipEn),
  .linearOrder(linearOrder), .curAddr(curAddr), .addrValid(addrValid),
  .cycType(cycType)
);

// File: tb/tb_burstAddrGen.sv
module tb_burstAddrGen;
  localparam int PERIOD = 10;
  localparam int AW = 20;

  typedef struct packed {
    logic          ps;
    logic          cs;
    logic          adv;
    logic          ce;
    logic          lin;
    logic [AW-1:0] addr;
    logic [AW-1:0] expAddr;
    logic          expV;
    logic [1:0]    expT;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TABLE [NV] = '{
    // ps cs adv ce lin addr       expAddr    v  type req
    '{1'b1,1'b0,1'b0,1'b1,1'b0,20'h12345,20'h12345,1'b1,2'd1,8'd2},  // R2 load
    '{1'b0,1'b0,1'b1,1'b1,1'b0,20'h00000,20'h12344,1'b1,2'd2,8'd6},  // R6 01^01
    '{1'b0,1'b0,1'b1,1'b1,1'b0,20'h00000,20'h12347,1'b1,2'd2,8'd6},  // R6 01^10
    '{1'b0,1'b0,1'b1,1'b1,1'b0,20'h00000,20'h12346,1'b1,2'd2,8'd6},  // R6 01^11
    '{1'b0,1'b0,1'b1,1'b1,1'b0,20'h00000,20'h12345,1'b1,2'd2,8'd9},  // R9 wrap
    '{1'b0,1'b0,1'b0,1'b1,1'b0,20'h00000,20'h12345,1'b1,2'd3,8'd8},  // R8 suspend
    '{1'b0,1'b1,1'b0,1'b1,1'b1,20'hABCDE,20'hABCDE,1'b1,2'd1,8'd3},  // R3 ctrl load linear
    '{1'b0,1'b0,1'b1,1'b1,1'b0,20'h00000,20'hABCDF,1'b1,2'd2,8'd10}, // R10 lin change ignored
    '{1'b0,1'b0,1'b1,1'b1,1'b0,20'h00000,20'hABCDC,1'b1,2'd2,8'd7},  // R7 10+2
    '{1'b0,1'b0,1'b1,1'b1,1'b1,20'h00000,20'hABCDD,1'b1,2'd2,8'd7},  // R7 10+3
    '{1'b1,1'b0,1'b0,1'b0,1'b0,20'h11111,20'hABCDD,1'b1,2'd3,8'd4},  // R4 proc ignored
    '{1'b0,1'b1,1'b0,1'b0,1'b0,20'h22222,20'hABCDD,1'b0,2'd0,8'd5},  // R5 deselect
    '{1'b0,1'b0,1'b1,1'b1,1'b0,20'h33333,20'hABCDD,1'b0,2'd0,8'd11}, // R11 advance idle
    '{1'b1,1'b1,1'b0,1'b1,1'b1,20'h00003,20'h00003,1'b1,2'd1,8'd12}, // R12 both strobes
    '{1'b1,1'b0,1'b0,1'b1,1'b0,20'h7FFFF,20'h7FFFF,1'b1,2'd1,8'd12}, // R12 back to back
    '{1'b0,1'b0,1'b1,1'b1,1'b1,20'h00000,20'h7FFFE,1'b1,2'd2,8'd9},  // R9 upper fixed
    '{1'b1,1'b0,1'b1,1'b0,1'b0,20'h00000,20'h7FFFD,1'b1,2'd2,8'd4}   // R4 proc ignored, steps
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic          procStart = 1'b0;
  logic          ctrlStart = 1'b0;
  logic          advance = 1'b0;
  logic          chipEn = 1'b0;
  logic          linearOrder = 1'b0;
  logic [AW-1:0] curAddr;
  logic          addrValid;
  logic [1:0]    cycType;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  burstAddrGen #(.AW(AW), .BB(2)) dut (
    .clk(clk), .rstN(rstN), .extAddr(extAddr), .procStart(procStart),
    .ctrlStart(ctrlStart), .advance(advance), .chipEn(chipEn),
    .linearOrder(linearOrder), .curAddr(curAddr), .addrValid(addrValid),
    .cycType(cycType)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOut(input string tag, input logic [AW-1:0] ea, input logic ev, input logic [1:0] et);
    check({tag, " addr"}, 32'(curAddr), 32'(ea));
    check({tag, " valid"}, 32'(addrValid), 32'(ev));
    check({tag, " type"}, 32'(cycType), 32'(et));
  endtask

  task automatic drive(input logic ps, input logic cs, input logic adv,
                       input logic ce, input logic lin, input logic [AW-1:0] a);
    procStart = ps; ctrlStart = cs; advance = adv; chipEn = ce;
    linearOrder = lin; extAddr = a;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, held over a few edges
    repeat (3) @(posedge clk);
    #2;
    checkOut("R1 in reset", '0, 1'b0, 2'd0);
    rstN = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    checkOut("R1 after release", '0, 1'b0, 2'd0);

    for (int i = 0; i < NV; i++) begin
      drive(TABLE[i].ps, TABLE[i].cs, TABLE[i].adv, TABLE[i].ce, TABLE[i].lin, TABLE[i].addr);
      checkOut($sformatf("R%0d vec%0d", TABLE[i].req, i), TABLE[i].expAddr, TABLE[i].expV, TABLE[i].expT);
    end

    // R7 linear wrap from low bits 11: 3 0 1 2 3
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 20'h5555B);
    checkOut("R7 load", 20'h5555B, 1'b1, 2'd1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, '0);
    checkOut("R7 step1", 20'h55558, 1'b1, 2'd2);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, '0);
    checkOut("R7 step2", 20'h55559, 1'b1, 2'd2);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, '0);
    checkOut("R7 step3", 20'h5555A, 1'b1, 2'd2);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, '0);
    checkOut("R9 linear wrap", 20'h5555B, 1'b1, 2'd2);

    // R6 interleaved start at low bits 10: 2 3 0 1
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0F0F2);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    checkOut("R6 ilv step1", 20'h0F0F3, 1'b1, 2'd2);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, '0);
    checkOut("R6 ilv step2", 20'h0F0F0, 1'b1, 2'd2);

    // R1 reset in mid burst
    rstN = 1'b0;
    #2;
    checkOut("R1 mid reset", '0, 1'b0, 2'd0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    rstN = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    checkOut("R11 after reset", '0, 1'b0, 2'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule